// File: doc/BRIEF.md
# Programmed-I/O Strobe Timing Generator

This block times the programmed-I/O register and data cycles of a disk interface with two channels of two drives each, four drive slots in all. Every slot has its own address-setup, strobe-width and recovery counts, held in bus clocks as the wanted length minus one. A requester raises a start with a drive index and a direction. The block then runs three phases in order. First it holds the address valid. Then it raises the read or the write strobe for the programmed width. Then it waits out the recovery time, pulses done, and returns to idle to take the next cycle.

The timing of a slot is copied when its cycle is accepted. Register writes made during a cycle therefore only affect later cycles. A start that arrives while the block is busy is dropped, and ready stays low until idle is reached.

A third register holds the per-slot ultra-DMA controls: an enable, an enable-method bit, a transfer-mode bit and a two-bit cycle-time code giving code+2 clocks. These only go out on ports; no DMA transfer is made here. At reset every timing field is at its maximum, which gives the slowest cycle.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, ready_o is 1, all strobes and done_o are 0, and every slot has setup 4, strobe width 16 and recovery 16 clocks. The ultra-DMA cycle codes are all 3, and the enable, method and mode bits are all 0.
- R2: A start accepted at a rising edge with ready_o high is followed by setup+1 clocks with addr_valid_o high and both strobes low. For slot d, setup is the 2-bit field at bits [7-2d:6-2d] of the setup register (cfg_sel_i=1, data bits 7:0).
- R3: After setup comes strobe+1 clocks with addr_valid_o high and exactly one strobe high: rd_strobe_o when write_i was 0, wr_strobe_o when it was 1. For slot d, strobe is the nibble at bits [31-8d:28-8d] of the timing word (cfg_sel_i=0).
- R4: After the strobe comes recovery+1 clocks with addr_valid_o and both strobes low. For slot d, recovery is the nibble at bits [27-8d:24-8d] of the timing word. done_o is high for exactly the last recovery clock, and ready_o is 1 in the clock after it.
- R5: ready_o is 0 from acceptance until the cycle ends. A start raised while ready_o is 0 is dropped and starts no cycle.
- R6: The slot's timing is captured on acceptance. A register write during a cycle does not change that cycle.
- R7: The ultra-DMA word (cfg_sel_i=2) gives slot d the byte at bits [31-8d:24-8d]. Bit 7 of that byte is the method bit, bit 6 the enable and bit 5 the mode bit (1 = PIO). Bits 1:0 are the cycle code, output on udma_cyc_o[2d+1:2d]. The single-bit fields appear on bit d of udma_meth_o, udma_en_o and udma_pio_o in the clock after the write.
- R8: A write with cfg_sel_i=3 changes no register.
- R9: cur_drive_o holds the accepted drive index from the first setup clock through done_o.
- R10: All-zero fields give the shortest cycle: 1 setup, 1 strobe and 1 recovery clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 timing, 1 setup, 2 ultra-DMA, 3 none |
| cfg_wdata_i | input | 32 | Register write data |
| start_i | input | 1 | Cycle request |
| drive_i | input | 2 | Drive slot of the request |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ready_o | output | 1 | Idle, can accept a start |
| addr_valid_o | output | 1 | Address valid (setup and strobe phases) |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| done_o | output | 1 | One-clock pulse at the end of recovery |
| cur_drive_o | output | 2 | Slot of the running cycle |
| udma_en_o | output | 4 | Ultra-DMA enable per slot |
| udma_meth_o | output | 4 | Enable-method bit per slot |
| udma_pio_o | output | 4 | Transfer-mode bit per slot |
| udma_cyc_o | output | 8 | Cycle-time code, 2 bits per slot |

## Verification
The first setup clock is visible one rising edge after acceptance. Every later phase follows directly, so a cycle lasts setup+strobe+recovery+3 clocks with done_o on its last clock and ready_o back one clock later. Register outputs change one edge after a write. A monitor samples on falling edges and counts the clocks of each phase per cycle. At each done_o it compares those counts, the strobe direction and the slot with the item the driver queued at acceptance, which was computed from a shadow of the registers at that moment.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  localparam int SETUP_W = 2;
  localparam int PULSE_W = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [PULSE_W-1:0] active;
    logic [PULSE_W-1:0] recov;
  } pio_timing_t;

  typedef struct packed {
    logic       meth;
    logic       en;
    logic       pio;
    logic [1:0] cyc;
  } udma_ctl_t;
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int REG_W = 8 * NUM_DRIVES,
  localparam int SET_W = SETUP_W * NUM_DRIVES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     timing_o,
  output logic [SET_W-1:0]     setup_o,
  output udma_ctl_t [NUM_DRIVES-1:0] udma_o
);
  logic [REG_W-1:0] timing_q;
  logic [SET_W-1:0] setup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '1;
      setup_q  <= '1;
    end else if (we_i) begin
      case (sel_i)
        2'd0:    timing_q <= wdata_i;
        2'd1:    setup_q  <= wdata_i[SET_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_udma
    localparam int B = (NUM_DRIVES - 1 - d) * 8;
    udma_ctl_t udma_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        udma_q <= '{meth: 1'b0, en: 1'b0, pio: 1'b0, cyc: 2'b11};
      end else if (we_i && sel_i == 2'd2) begin
        udma_q <= '{meth: wdata_i[B+7], en: wdata_i[B+6], pio: wdata_i[B+5],
                    cyc: wdata_i[B+1:B]};
      end
    end
    assign udma_o[d] = udma_q;
  end

  assign timing_o = timing_q;
  assign setup_o  = setup_q;
endmodule

// File: rtl/pio_field_mux.sv
module pio_field_mux
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int REG_W = 8 * NUM_DRIVES,
  localparam int SET_W = SETUP_W * NUM_DRIVES,
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input  logic [REG_W-1:0]           timing_i,
  input  logic [SET_W-1:0]           setup_i,
  input  udma_ctl_t [NUM_DRIVES-1:0] udma_i,
  input  logic [DRV_W-1:0]           drive_i,
  output pio_timing_t                sel_o,
  output logic [NUM_DRIVES-1:0]      udma_en_o,
  output logic [NUM_DRIVES-1:0]      udma_meth_o,
  output logic [NUM_DRIVES-1:0]      udma_pio_o,
  output logic [2*NUM_DRIVES-1:0]    udma_cyc_o
);
  pio_timing_t [NUM_DRIVES-1:0] tim;

  // slot 0 sits in the most significant byte / bit pair
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    localparam int B = (NUM_DRIVES - 1 - d) * 8;
    localparam int S = (NUM_DRIVES - 1 - d) * SETUP_W;
    assign tim[d] = {setup_i[S +: SETUP_W], timing_i[B+4 +: PULSE_W],
                     timing_i[B +: PULSE_W]};
    assign udma_en_o[d]        = udma_i[d].en;
    assign udma_meth_o[d]      = udma_i[d].meth;
    assign udma_pio_o[d]       = udma_i[d].pio;
    assign udma_cyc_o[2*d +: 2] = udma_i[d].cyc;
  end

  assign sel_o = tim[drive_i];
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int DRV_W = $clog2(NUM_DRIVES),
  localparam int CNT_W = PULSE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DRV_W-1:0] drive_i,
  input  logic             write_i,
  input  pio_timing_t      tim_i,
  output logic             ready_o,
  output logic             addr_valid_o,
  output logic             rd_strobe_o,
  output logic             wr_strobe_o,
  output logic             done_o,
  output logic [DRV_W-1:0] cur_drive_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  pio_timing_t      lat_q;
  logic [DRV_W-1:0] drv_q;
  logic             wr_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lat_q   <= '0;
      drv_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          lat_q   <= tim_i;
          drv_q   <= drive_i;
          wr_q    <= write_i;
          cnt_q   <= CNT_W'(tim_i.setup);
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (last) begin
          cnt_q   <= lat_q.active;
          phase_q <= PH_ACTIVE;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACTIVE: if (last) begin
          cnt_q   <= lat_q.recov;
          phase_q <= PH_RECOV;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (last) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ready_o      = (phase_q == PH_IDLE);
  assign addr_valid_o = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE);
  assign rd_strobe_o  = (phase_q == PH_ACTIVE) && !wr_q;
  assign wr_strobe_o  = (phase_q == PH_ACTIVE) && wr_q;
  assign done_o       = (phase_q == PH_RECOV) && last;
  assign cur_drive_o  = drv_q;
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int REG_W = 8 * NUM_DRIVES,
  localparam int SET_W = SETUP_W * NUM_DRIVES,
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [REG_W-1:0]        cfg_wdata_i,
  input  logic                    start_i,
  input  logic [DRV_W-1:0]        drive_i,
  input  logic                    write_i,
  output logic                    ready_o,
  output logic                    addr_valid_o,
  output logic                    rd_strobe_o,
  output logic                    wr_strobe_o,
  output logic                    done_o,
  output logic [DRV_W-1:0]        cur_drive_o,
  output logic [NUM_DRIVES-1:0]   udma_en_o,
  output logic [NUM_DRIVES-1:0]   udma_meth_o,
  output logic [NUM_DRIVES-1:0]   udma_pio_o,
  output logic [2*NUM_DRIVES-1:0] udma_cyc_o
);
  logic [REG_W-1:0]           timing_w;
  logic [SET_W-1:0]           setup_w;
  udma_ctl_t [NUM_DRIVES-1:0] udma_w;
  pio_timing_t                tim_sel;

  pio_regfile #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .timing_o(timing_w), .setup_o(setup_w), .udma_o(udma_w)
  );

  pio_field_mux #(.NUM_DRIVES(NUM_DRIVES)) u_mux (
    .timing_i(timing_w), .setup_i(setup_w), .udma_i(udma_w),
    .drive_i, .sel_o(tim_sel),
    .udma_en_o, .udma_meth_o, .udma_pio_o, .udma_cyc_o
  );

  pio_cycle_fsm #(.NUM_DRIVES(NUM_DRIVES)) u_fsm (
    .clk_i, .rst_ni, .start_i, .drive_i, .write_i, .tim_i(tim_sel),
    .ready_o, .addr_valid_o, .rd_strobe_o, .wr_strobe_o, .done_o, .cur_drive_o
  );
endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker #(
  parameter int NUM_DRIVES = 4,
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ready_o,
  input logic             addr_valid_o,
  input logic             rd_strobe_o,
  input logic             wr_strobe_o,
  input logic             done_o,
  input logic [DRV_W-1:0] cur_drive_o
);
  assert_one_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_o && wr_strobe_o));

  assert_accept_to_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> (addr_valid_o && !ready_o && !rd_strobe_o && !wr_strobe_o));

  assert_strobe_after_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_strobe_o) || $rose(wr_strobe_o)) |-> $past(addr_valid_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  assert_busy_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o || done_o) |-> !ready_o);

  assert_drive_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> $stable(cur_drive_o));
endmodule

bind pio_strobe_timer pio_strobe_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
  .clk_i, .rst_ni, .start_i, .ready_o, .addr_valid_o, .rd_strobe_o,
  .wr_strobe_o, .done_o, .cur_drive_o
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_we, start, write;
  logic [1:0]  cfg_sel, drive;
  logic [31:0] cfg_wdata;
  logic        ready, addr_valid, rd_s, wr_s, done;
  logic [1:0]  cur_drive;
  logic [3:0]  u_en, u_meth, u_pio;
  logic [7:0]  u_cyc;

  pio_strobe_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .start_i(start), .drive_i(drive), .write_i(write),
    .ready_o(ready), .addr_valid_o(addr_valid), .rd_strobe_o(rd_s),
    .wr_strobe_o(wr_s), .done_o(done), .cur_drive_o(cur_drive),
    .udma_en_o(u_en), .udma_meth_o(u_meth), .udma_pio_o(u_pio), .udma_cyc_o(u_cyc)
  );

  typedef struct {int drv; bit wr; int s; int a; int r; string req;} exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, pushed = 0, popped = 0;
  logic [31:0] sh_tim = 32'hFFFF_FFFF;
  logic [7:0]  sh_set = 8'hFF;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) sh_tim = d;
    else if (sel == 2'd1) sh_set = d[7:0];
  endtask

  task automatic run(input int d, input bit w, input string req);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    start = 1'b1; drive = 2'(d); write = w;
    e.drv = d; e.wr = w; e.req = req;
    e.s = int'((sh_set >> (6 - 2*d)) & 8'h3) + 1;
    e.a = int'((sh_tim >> (28 - 8*d)) & 32'hF) + 1;
    e.r = int'((sh_tim >> (24 - 8*d)) & 32'hF) + 1;
    q.push_back(e); pushed++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: count phase clocks, compare at done
  int ns = 0, nrd = 0, nwr = 0, nr = 0;
  bit ready_due = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready_due) begin
        chk(ready == 1'b1, "R4 ready after done", int'(ready), 1);
        ready_due = 1'b0;
      end
      if (addr_valid && !rd_s && !wr_s) ns++;
      if (rd_s) nrd++;
      if (wr_s) nwr++;
      if (!ready && !addr_valid) nr++;
      if (done) begin
        if (q.size() == 0) chk(1'b0, "R5 unexpected cycle", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front(); popped++;
          chk(ns == e.s, {e.req, " R2 setup clocks"}, ns, e.s);
          chk((e.wr ? nwr : nrd) == e.a, {e.req, " R3 strobe clocks"}, e.wr ? nwr : nrd, e.a);
          chk((e.wr ? nrd : nwr) == 0, {e.req, " R3 wrong strobe"}, e.wr ? nrd : nwr, 0);
          chk(nr == e.r, {e.req, " R4 recovery clocks"}, nr, e.r);
          chk(int'(cur_drive) == e.drv, {e.req, " R9 drive"}, int'(cur_drive), e.drv);
        end
        ns = 0; nrd = 0; nwr = 0; nr = 0;
        ready_due = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    start = 1'b0; drive = '0; write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk({rd_s, wr_s, done, addr_valid} == 4'b0, "R1 idle outputs", int'({rd_s, wr_s, done, addr_valid}), 0);
    chk(u_cyc == 8'hFF, "R1 udma cyc", int'(u_cyc), 255);
    chk({u_en, u_meth, u_pio} == 12'h0, "R1 udma bits", int'({u_en, u_meth, u_pio}), 0);

    run(0, 1'b0, "R1 default timing");
    run(3, 1'b1, "R1 default timing");

    // R2 R3 R4 R8: per-slot fields
    wr_cfg(2'd0, 32'h1234_05F0);
    wr_cfg(2'd1, 32'hFFFF_FF1B);
    run(0, 1'b0, "R2 slot0");
    run(1, 1'b1, "R3 slot1");
    run(2, 1'b0, "R4 slot2");
    run(3, 1'b1, "R8 slot3");

    // R8: select 3 writes nothing
    wr_cfg(2'd3, 32'h0000_0000);
    @(negedge clk);
    chk(u_cyc == 8'hFF, "R8 udma kept", int'(u_cyc), 255);
    run(1, 1'b0, "R8 timing kept");

    // R6: write during a running cycle
    run(2, 1'b1, "R6 latched");
    wr_cfg(2'd0, 32'h0000_0000);
    wr_cfg(2'd1, 32'h0000_0000);
    // R10: shortest cycle
    run(2, 1'b0, "R10 minimum");
    run(0, 1'b1, "R10 minimum");

    // R5: start while busy is dropped
    wr_cfg(2'd0, 32'h33333333);
    run(1, 1'b0, "R5 held off");
    start = 1'b1; drive = 2'd3; write = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R5 busy ready low", int'(ready), 0);
    @(negedge clk);
    start = 1'b0;
    while (!ready || q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ready == 1'b1 && addr_valid == 1'b0, "R5 no extra cycle", int'(addr_valid), 0);

    // R7: ultra-DMA controls; slot bytes C3,41,22,80
    wr_cfg(2'd2, 32'hC341_2280);
    chk(u_en == 4'b0011, "R7 en", int'(u_en), 3);
    chk(u_meth == 4'b1001, "R7 meth", int'(u_meth), 9);
    chk(u_pio == 4'b0100, "R7 pio", int'(u_pio), 4);
    chk(u_cyc == 8'h27, "R7 cyc", int'(u_cyc), 39);
    wr_cfg(2'd3, 32'hFFFF_FFFF);
    chk(u_cyc == 8'h27 && u_en == 4'b0011, "R8 sel3 udma", int'(u_cyc), 39);

    while (!ready || q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(popped == pushed, "R5 cycle count", popped, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule